// File: doc/BRIEF.md
# Address Latch Enable Strobe Generator

This block produces the address latch enable (ALE) strobe of an 8051-style multiplexed external memory bus. A free-running slot timer divides the oscillator clock into bus slots of three phases each. ALE is driven high for the first phase of every slot and low for the other two. In 12-clock core mode a phase lasts two oscillator clocks, so ALE repeats every six clocks. In 6-clock core mode a phase lasts one oscillator clock, so ALE repeats every three clocks.

A two-bit auxiliary configuration register lives inside the block. Bit 0 is the ALE-disable bit and bit 1 is the extra-data-RAM disable bit. The block only holds bit 1 and shows it on an output. When bit 0 is set, ALE is suppressed except for slots that are requested for external data-move or code-move accesses, which lowers EMI on an idle bus. A request is seen only at a slot boundary, so a gated pulse is always a whole pulse.

Top module: `ale_strobe_gen`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), both configuration bits read 0. ALE is high in the first cycle after reset and keeps running with no request.
- R2: With x6_mode low during a slot (12-clock mode), the slot lasts 6 clocks and ALE is high for its first 2 clocks, which is one sixth of the oscillator rate.
- R3: With x6_mode high during a slot (6-clock mode), the slot lasts 3 clocks and ALE is high for its first clock, which is one third of the oscillator rate.
- R4: In every slot where ALE is emitted, it is high for exactly one phase and low for the two phases that follow.
- R5: With ale_gate = 1, a slot whose boundary edge sees xacc_req low has no ALE pulse at all.
- R6: With ale_gate = 1, a slot whose boundary edge sees xacc_req high carries a full ALE pulse. A request that rises inside a slot produces no pulse before the next boundary.
- R7: x6_mode is sampled at the reset edge and at each slot-boundary edge. A change inside a slot takes effect only with the next slot.
- R8: A clock edge with cfg_we high stores cfg_wdata, with bit 0 as the ALE-disable bit and bit 1 as the RAM-disable bit. Both bits appear on ale_gate and xram_off in the next cycle. With cfg_we low, cfg_wdata is ignored.
- R9: A configuration write that lands on a slot-boundary edge does not affect that boundary's gating decision, which uses the value held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| x6_mode | input | 1 | 1: 6-clock core mode, 0: 12-clock core mode |
| cfg_we | input | 1 | Write strobe of the auxiliary configuration register |
| cfg_wdata | input | 2 | Write data: bit 0 ALE-disable, bit 1 RAM-disable |
| xacc_req | input | 1 | External data-move or code-move access in progress |
| ale | output | 1 | Address latch enable strobe |
| ale_gate | output | 1 | Stored ALE-disable bit |
| xram_off | output | 1 | Stored extra-RAM disable bit |

## Verification
The bench builds the block with its default parameters: three phases per slot, and phase lengths of one and two clocks. Both bus rates therefore show up in slots of only three and six cycles. Mode flips inside a slot, requests that rise in mid-slot, and configuration writes that land on a boundary edge all occur within a few dozen cycles. The behavioural model follows one integer slot position, so every one of these orderings is compared on every clock.

// File: rtl/ale_pkg.sv
// Shared definitions for the ALE strobe generator.
// Assumes the auxiliary register keeps its bit order: bit 0 gates ALE, bit 1 disables the extra RAM.
package ale_pkg;
    localparam int unsigned AUX_W = 2;

    typedef struct packed {
        logic xram_off;   // bit 1
        logic ale_gate;   // bit 0
    } aux_cfg_t;
endpackage

// File: rtl/ale_cfg_reg.sv
// Auxiliary configuration register.
// Stores the ALE-disable and RAM-disable bits and clears both on reset.
module ale_cfg_reg
    import ale_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  aux_cfg_t wdata,
    output aux_cfg_t cfg_q
);
    // Hold the configuration bits and load them on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= wdata;
        end
    end
endmodule

// File: rtl/ale_slot_timer.sv
// Bus slot timer.
// Divides the clock into phases and groups PHASES phases into one slot.
// The core mode is latched at reset and at every slot end.
// Assumes FAST_CLKS <= SLOW_CLKS and PHASES >= 2.
module ale_slot_timer #(
    parameter int unsigned PHASES    = 3,
    parameter int unsigned FAST_CLKS = 1,
    parameter int unsigned SLOW_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic x6_mode,
    output logic fast_q,
    output logic phase_first,
    output logic slot_end
);
    localparam int unsigned SUB_W = (SLOW_CLKS > 1) ? $clog2(SLOW_CLKS) : 1;
    localparam int unsigned PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam logic [SUB_W-1:0] FAST_LAST = SUB_W'(FAST_CLKS - 1);
    localparam logic [SUB_W-1:0] SLOW_LAST = SUB_W'(SLOW_CLKS - 1);
    localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(PHASES - 1);

    logic [SUB_W-1:0] sub_q;
    logic [PH_W-1:0]  ph_q;
    logic [SUB_W-1:0] sub_last;
    logic             phase_end;

    // Select the last clock index of a phase for the latched mode.
    always_comb begin
        sub_last  = fast_q ? FAST_LAST : SLOW_LAST;
        phase_end = (sub_q == sub_last);
    end

    assign slot_end    = phase_end && (ph_q == PH_LAST);
    assign phase_first = (ph_q == '0);

    // Advance the clock-in-phase and phase-in-slot counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q  <= '0;
            ph_q   <= '0;
            fast_q <= x6_mode;
        end else if (slot_end) begin
            sub_q  <= '0;
            ph_q   <= '0;
            fast_q <= x6_mode;
        end else if (phase_end) begin
            sub_q  <= '0;
            ph_q   <= ph_q + 1'b1;
        end else begin
            sub_q  <= sub_q + 1'b1;
        end
    end
endmodule

// File: rtl/ale_gate_ctrl.sv
// Slot enable for ALE.
// Decides once per slot, at the boundary edge, whether the next slot carries a pulse.
// Because the decision is made only there, a gated pulse is never partial.
module ale_gate_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_end,
    input  logic phase_first,
    input  logic gate_on,
    input  logic xacc_req,
    output logic ale
);
    logic en_q;

    // Latch the per-slot enable; reset leaves the strobe free-running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b1;
        end else if (slot_end) begin
            en_q <= !gate_on || xacc_req;
        end
    end

    assign ale = en_q && phase_first;
endmodule

// File: rtl/ale_strobe_gen.sv
// ALE strobe generator top.
// Joins the configuration register, the slot timer and the slot enable.
// Assumes clk is the oscillator clock and all inputs are synchronous to it.
module ale_strobe_gen #(
    parameter int unsigned PHASES    = 3,
    parameter int unsigned FAST_CLKS = 1,
    parameter int unsigned SLOW_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       x6_mode,
    input  logic       cfg_we,
    input  logic [1:0] cfg_wdata,
    input  logic       xacc_req,
    output logic       ale,
    output logic       ale_gate,
    output logic       xram_off
);
    import ale_pkg::*;

    aux_cfg_t cfg_q;
    logic     fast_q;
    logic     phase_first;
    logic     slot_end;

    ale_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (aux_cfg_t'(cfg_wdata)),
        .cfg_q (cfg_q)
    );

    ale_slot_timer #(
        .PHASES    (PHASES),
        .FAST_CLKS (FAST_CLKS),
        .SLOW_CLKS (SLOW_CLKS)
    ) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .x6_mode     (x6_mode),
        .fast_q      (fast_q),
        .phase_first (phase_first),
        .slot_end    (slot_end)
    );

    ale_gate_ctrl u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_end    (slot_end),
        .phase_first (phase_first),
        .gate_on     (cfg_q.ale_gate),
        .xacc_req    (xacc_req),
        .ale         (ale)
    );

    assign ale_gate = cfg_q.ale_gate;
    assign xram_off = cfg_q.xram_off;
endmodule

// File: rtl/ale_strobe_chk.sv
// Property checker for the ALE strobe generator, bound into the top.
// Assumes the default phase lengths of one and two clocks.
module ale_strobe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ale,
    input logic       ale_gate,
    input logic       xacc_req,
    input logic       slot_end,
    input logic       fast_q,
    input logic       cfg_we,
    input logic [1:0] cfg_wdata
);
    AST_NO_PARTIAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> $past(slot_end)); // R6
    AST_GATED_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_end && ale_gate && !xacc_req) |=> !ale); // R5
    AST_UNGATED_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_end && !ale_gate) |=> ale); // R4
    AST_FAST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && fast_q) |=> !ale); // R3
    AST_SLOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ale) && !fast_q) |=> ale); // R2
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (ale_gate == $past(cfg_wdata[0]))); // R8
endmodule

bind ale_strobe_gen ale_strobe_chk u_chk (.*);

// File: tb/sim_ale_strobe_gen.sv
`timescale 1ns/1ps
// Bench for the ALE strobe generator: behavioural slot-position model compared every cycle.
module sim_ale_strobe_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       x6_mode = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_wdata = 2'b00;
    logic       xacc_req = 1'b0;
    logic       ale, ale_gate, xram_off;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    armed = 0;
    bit    done  = 0;
    string tag   = "R1";

    // Model state: position in slot, slot length, pulse length, slot enable, register bits.
    int       m_pos = 0;
    int       m_len = 6;
    int       m_hi  = 2;
    bit       m_en  = 1;
    bit [1:0] m_aux = 2'b00;
    int       hi_count = 0;

    ale_strobe_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .x6_mode   (x6_mode),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .xacc_req  (xacc_req),
        .ale       (ale),
        .ale_gate  (ale_gate),
        .xram_off  (xram_off)
    );

    always #10 clk = ~clk;

    // Reference model, stepped on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0;
            m_len = x6_mode ? 3 : 6;
            m_hi  = x6_mode ? 1 : 2;
            m_en  = 1;
            m_aux = 2'b00;
        end else begin
            if (m_pos == m_len - 1) begin
                m_pos = 0;
                m_len = x6_mode ? 3 : 6;   // R7 mode taken at boundary
                m_hi  = x6_mode ? 1 : 2;
                m_en  = !m_aux[0] || xacc_req; // R9 old register value used
            end else begin
                m_pos = m_pos + 1;
            end
            if (cfg_we) m_aux = cfg_wdata;
        end
    end

    task automatic check(input string req, input string what, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            check(tag, "ale", int'(ale), int'(m_en && (m_pos < m_hi)));
            check("R8", "ale_gate", int'(ale_gate), int'(m_aux[0]));
            check("R8", "xram_off", int'(xram_off), int'(m_aux[1]));
            if (ale) hi_count++;
        end
    end

    task automatic run(input int n, input string t);
        tag = t;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "reset ale", int'(ale), 1);
        check("R1", "reset ale_gate", int'(ale_gate), 0);
        check("R1", "reset xram_off", int'(xram_off), 0);
        armed = 1;
        run(36, "R2");                      // 12-clock free-running
        hi_count = 0;
        run(36, "R4");
        check("R2", "high cycles in 36 (12-clk)", hi_count, 12);
        wr(2'b10);                          // RAM disable only
        run(8, "R8");
        cfg_wdata = 2'b11;                  // ignored without strobe
        run(8, "R8");
        cfg_wdata = 2'b00;
        x6_mode = 1'b1;                     // mid-slot mode change
        run(10, "R7");
        hi_count = 0;
        run(30, "R3");
        check("R3", "high cycles in 30 (6-clk)", hi_count, 10);
        wr(2'b01);                          // gate ALE
        run(6, "R5");
        hi_count = 0;
        run(24, "R5");
        check("R5", "gated idle high cycles", hi_count, 0);
        @(negedge clk); @(negedge clk);
        xacc_req = 1'b1;                    // rises inside a slot
        run(20, "R6");
        xacc_req = 1'b0;
        x6_mode = 1'b0;
        run(20, "R6");
        xacc_req = 1'b1;
        run(30, "R6");
        xacc_req = 1'b0;
        // R9 writes toggling across boundary edges
        for (int i = 0; i < 14; i++) begin
            wr(i[0] ? 2'b01 : 2'b00);
            xacc_req = i[1];
            run(i % 5, "R9");
        end
        // Reset in 6-clock mode: mode sampled at reset
        @(negedge clk);
        armed = 0;
        rst_n = 1'b0;
        x6_mode = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        armed = 1;
        run(30, "R7");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog run did not complete got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule